// File: doc/BRIEF.md
# Wakeup Pin Monitor

This block watches a parameterised set of wakeup pins from the always-on domain. Each pin can be armed for a rising edge, a falling edge, both edges, or a level of either polarity. Every detected condition sets a sticky status bit. The block raises a wake request while any pin has both its status bit and its enable bit set. Software programs the block through a word-addressed 32-bit register port. It clears the status words by plain overwrite before the system goes to sleep.

The register space opens with two 32-bit timer words, which are plain read/write storage. Five banks follow: enable, falling-edge, rising-edge, polarity and status. Each bank is `NW = ceil(PINS/32)` words long. Software sees a pending pin as status AND enable.

Read data flows out as a one-beat response qualified by `rd_valid_o`. The response has no ready signal, so the consumer must accept it in the cycle it appears. There is no back-pressure on this path. Writes take effect at the clock edge on which they are presented.

Top module: `wakeup_monitor`

## Requirements
- R1: While reset is held and directly after it, every timer, enable, falling-edge, rising-edge, polarity and status word reads 0, and `wake_o` is 0.
- R2: Word address 0 and word address 1 are the two timer storage words. Word address `2 + b*NW + i` is word i of bank b, where b = 0 is enable, 1 is falling-edge, 2 is rising-edge, 3 is polarity and 4 is status. With the default PINS=64 (NW=2), enable is at 2..3, falling-edge at 4..5, rising-edge at 6..7, polarity at 8..9 and status at 10..11.
- R3: Pin p is configured and reported by bit (p mod 32) of word (p div 32) in every bank.
- R4: When a pin's rising-edge bit is set, a low-to-high transition sets its status bit. A high-to-low transition does not set it unless the falling-edge bit is also set.
- R5: When a pin's falling-edge bit is set, a high-to-low transition sets its status bit.
- R6: When both edge bits of a pin are set, either transition sets its status bit.
- R7: When neither edge bit of a pin is set, its status bit is set on every cycle the synchronised pin equals its polarity bit: high if the polarity bit is 1, low if it is 0.
- R8: A status bit is set by a detection even when the pin's enable bit is 0. It stays set until software writes the status word.
- R9: A detection in the same cycle as a write to its status word wins, so the bit reads back as 1.
- R10: `wake_o` is 1 exactly when some pin has both its status bit and its enable bit set.
- R11: Each pin passes through two synchroniser flops, which reset to 1, before detection. A pin change driven before clock edge A sets its status bit, and `wake_o` if enabled, at the third edge counted from A.
- R12: A read presented at a clock edge returns data, with `rd_valid_o` high, for exactly the following cycle. Addresses outside the map read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | PINS | Asynchronous wakeup pins |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_addr_i | input | AW | Word address |
| reg_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read response valid, one cycle after the read |
| rd_data_o | output | 32 | Read response data |
| wake_o | output | 1 | Wake request |

## Verification
The checker watches four things on every cycle:
- status bits are never lost unless the status bank is written;
- `wake_o` never rises without a set enable bit and a set status bit;
- the read response follows each read strobe one cycle later;
- everything is quiet at reset release.

Only the bench scenarios can show the rest: the choice of edge or level per pin, the bit and word placement of each pin, detection winning over a clearing write, and the exact synchroniser latency. The bench shows these by toggling chosen pins and reading the banks back through the port.

// File: rtl/wkm_pkg.sv
package wkm_pkg;
  localparam int unsigned HDR_WORDS = 2;
  localparam int unsigned BANK_EN   = 0;
  localparam int unsigned BANK_FALL = 1;
  localparam int unsigned BANK_RISE = 2;
  localparam int unsigned BANK_POL  = 3;
  localparam int unsigned BANK_STAT = 4;
  localparam int unsigned CFG_BANKS = 4;

  function automatic int unsigned word_count(input int unsigned pins);
    return (pins + 31) / 32;
  endfunction
endpackage

// File: rtl/wkm_sync.sv
module wkm_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic cur_o,
  output logic last_o
);
  logic meta_q, cur_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      cur_q  <= RST_VAL;
      last_q <= RST_VAL;
    end else begin
      meta_q <= pin_i;
      cur_q  <= meta_q;
      last_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign last_o = last_q;
endmodule

// File: rtl/wkm_detect.sv
module wkm_detect #(
  parameter int unsigned PINS = 64
) (
  input  logic [PINS-1:0] cur_i,
  input  logic [PINS-1:0] last_i,
  input  logic [PINS-1:0] rise_en_i,
  input  logic [PINS-1:0] fall_en_i,
  input  logic [PINS-1:0] pol_i,
  output logic [PINS-1:0] hit_o
);
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic up, down, lvl, edge_mode;
    assign up        = cur_i[p] & ~last_i[p];
    assign down      = ~cur_i[p] & last_i[p];
    assign lvl       = ~(cur_i[p] ^ pol_i[p]);
    assign edge_mode = rise_en_i[p] | fall_en_i[p];
    assign hit_o[p]  = edge_mode ? ((rise_en_i[p] & up) | (fall_en_i[p] & down)) : lvl;
  end
endmodule

// File: rtl/wkm_regs.sv
module wkm_regs #(
  parameter int unsigned PINS = 64,
  parameter int unsigned AW   = 8,
  localparam int unsigned NW  = wkm_pkg::word_count(PINS),
  localparam int unsigned BITS = NW * 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  input  logic [PINS-1:0] hit_i,
  output logic            rd_valid_o,
  output logic [31:0]     rd_data_o,
  output logic [BITS-1:0] en_o,
  output logic [BITS-1:0] fall_o,
  output logic [BITS-1:0] rise_o,
  output logic [BITS-1:0] pol_o,
  output logic [BITS-1:0] stat_o
);
  import wkm_pkg::*;

  logic [31:0] timer_q [HDR_WORDS];
  logic [31:0] cfg_q   [CFG_BANKS][NW];
  logic [31:0] stat_q  [NW];
  logic [BITS-1:0] hit_w;
  logic [31:0] rd_mux;
  logic        rd_valid_q;
  logic [31:0] rd_data_q;

  always_comb begin
    hit_w = '0;
    hit_w[PINS-1:0] = hit_i;
  end

  always_comb begin
    rd_mux = '0;
    for (int t = 0; t < HDR_WORDS; t++)
      if (addr_i == AW'(t)) rd_mux = timer_q[t];
    for (int b = 0; b < CFG_BANKS; b++)
      for (int w = 0; w < NW; w++)
        if (addr_i == AW'(HDR_WORDS + b * NW + w)) rd_mux = cfg_q[b][w];
    for (int w = 0; w < NW; w++)
      if (addr_i == AW'(HDR_WORDS + BANK_STAT * NW + w)) rd_mux = stat_q[w];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < HDR_WORDS; t++) timer_q[t] <= '0;
      for (int b = 0; b < CFG_BANKS; b++)
        for (int w = 0; w < NW; w++) cfg_q[b][w] <= '0;
      for (int w = 0; w < NW; w++) stat_q[w] <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      for (int t = 0; t < HDR_WORDS; t++)
        if (wr_i && addr_i == AW'(t)) timer_q[t] <= wdata_i;
      for (int b = 0; b < CFG_BANKS; b++)
        for (int w = 0; w < NW; w++)
          if (wr_i && addr_i == AW'(HDR_WORDS + b * NW + w)) cfg_q[b][w] <= wdata_i;
      for (int w = 0; w < NW; w++)
        stat_q[w] <= ((wr_i && addr_i == AW'(HDR_WORDS + BANK_STAT * NW + w)) ? wdata_i : stat_q[w])
                     | hit_w[w*32 +: 32];
      rd_valid_q <= rd_i;
      if (rd_i) rd_data_q <= rd_mux;
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_flat
    assign en_o[w*32 +: 32]   = cfg_q[BANK_EN][w];
    assign fall_o[w*32 +: 32] = cfg_q[BANK_FALL][w];
    assign rise_o[w*32 +: 32] = cfg_q[BANK_RISE][w];
    assign pol_o[w*32 +: 32]  = cfg_q[BANK_POL][w];
    assign stat_o[w*32 +: 32] = stat_q[w];
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
endmodule

// File: rtl/wakeup_monitor.sv
module wakeup_monitor #(
  parameter int unsigned PINS = 64,
  parameter int unsigned AW   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PINS-1:0] pins_i,
  input  logic            reg_wr_i,
  input  logic            reg_rd_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic            rd_valid_o,
  output logic [31:0]     rd_data_o,
  output logic            wake_o
);
  localparam int unsigned NW   = wkm_pkg::word_count(PINS);
  localparam int unsigned BITS = NW * 32;

  logic [PINS-1:0] cur, last, hit;
  logic [BITS-1:0] en_flat, fall_flat, rise_flat, pol_flat, stat_flat;

  for (genvar p = 0; p < PINS; p++) begin : g_sync
    wkm_sync #(.RST_VAL(1'b1)) i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pins_i[p]),
      .cur_o (cur[p]),
      .last_o(last[p])
    );
  end

  wkm_detect #(.PINS(PINS)) i_detect (
    .cur_i    (cur),
    .last_i   (last),
    .rise_en_i(rise_flat[PINS-1:0]),
    .fall_en_i(fall_flat[PINS-1:0]),
    .pol_i    (pol_flat[PINS-1:0]),
    .hit_o    (hit)
  );

  wkm_regs #(.PINS(PINS), .AW(AW)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .hit_i     (hit),
    .rd_valid_o(rd_valid_o),
    .rd_data_o (rd_data_o),
    .en_o      (en_flat),
    .fall_o    (fall_flat),
    .rise_o    (rise_flat),
    .pol_o     (pol_flat),
    .stat_o    (stat_flat)
  );

  assign wake_o = |(stat_flat & en_flat);
endmodule

// File: rtl/wkm_checker.sv
module wkm_checker #(
  parameter int unsigned AW = 8,
  parameter int unsigned NW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [AW-1:0]    reg_addr,
  input logic             rd_valid,
  input logic             wake,
  input logic [NW*32-1:0] status,
  input logic [NW*32-1:0] enable
);
  localparam int unsigned STAT_BASE = 2 + 4 * NW;
  logic stat_wr;
  assign stat_wr = reg_wr && (reg_addr >= AW'(STAT_BASE)) && (reg_addr < AW'(STAT_BASE + NW));

  AST_QUIET_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (status == '0 && enable == '0 && !wake)); // R1
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status & $past(status)) == $past(status))); // R8
  AST_WAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (enable != '0)); // R10
  AST_WAKE_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (status != '0)); // R10
  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> rd_valid); // R12
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !rd_valid); // R12
endmodule

bind wakeup_monitor wkm_checker #(.AW(AW), .NW(NW)) i_wkm_checker (
  .clk     (clk_i),
  .rst_n   (rst_ni),
  .reg_wr  (reg_wr_i),
  .reg_rd  (reg_rd_i),
  .reg_addr(reg_addr_i),
  .rd_valid(rd_valid_o),
  .wake    (wake_o),
  .status  (stat_flat),
  .enable  (en_flat)
);

// File: tb/test_wakeup_monitor.sv
module test_wakeup_monitor;
  localparam int unsigned PINS = 64;
  localparam int unsigned AW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PINS-1:0] pins = '1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic rd_valid, wake;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  wakeup_monitor #(.PINS(PINS), .AW(AW)) i_wakeup_monitor (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .wake_o(wake)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = AW'(a);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected response", rd_data, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data === e, t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    check(wake === 1'b0, "R1 wake in reset", {31'h0, wake}, 32'h0);
    check(rd_valid === 1'b0, "R1 rd_valid in reset", {31'h0, rd_valid}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 12; a++) rd(a, 32'h0, "R1 R2 word zero after reset");

    // Timer storage and unmapped space
    wr(0, 32'hA5A5_0001);
    wr(1, 32'h0000_BEEF);
    wr(20, 32'hFFFF_FFFF);
    rd(0, 32'hA5A5_0001, "R2 timer word 0");
    rd(1, 32'h0000_BEEF, "R2 timer word 1");
    rd(2, 32'h0, "R2 enable untouched by timer write");
    rd(20, 32'h0, "R12 unmapped reads zero");
    idle(1);
    check(rd_valid === 1'b0, "R12 no response when idle", {31'h0, rd_valid}, 32'h0);

    // Rising edge on pin 5
    wr(6, 32'h20);
    pins[5] = 1'b0; idle(5);
    rd(10, 32'h0, "R4 falling edge ignored with only rise armed");
    pins[5] = 1'b1; idle(5);
    rd(10, 32'h20, "R4 R8 rising edge sets status with enable clear");
    check(wake === 1'b0, "R10 no wake while enable clear", {31'h0, wake}, 32'h0);
    wr(2, 32'h20); idle(1);
    check(wake === 1'b1, "R10 wake once enabled", {31'h0, wake}, 32'h1);
    wr(10, 32'h0); idle(1);
    check(wake === 1'b0, "R10 wake drops after status clear", {31'h0, wake}, 32'h0);
    rd(10, 32'h0, "R8 status cleared by overwrite");

    // Falling edge on pin 40 (word 1 bit 8)
    wr(5, 32'h100);
    pins[40] = 1'b0; idle(5);
    rd(11, 32'h100, "R5 R3 falling edge pin 40");
    pins[40] = 1'b1; idle(5);
    rd(11, 32'h100, "R8 status sticky after pin returns");
    wr(11, 32'h0);

    // Both edges on pin 33 (word 1 bit 1)
    wr(7, 32'h2);
    wr(5, 32'h102);
    pins[33] = 1'b0; idle(5);
    rd(11, 32'h2, "R6 falling edge with both armed");
    wr(11, 32'h0);
    pins[33] = 1'b1; idle(5);
    rd(11, 32'h2, "R6 rising edge with both armed");
    wr(11, 32'h0);
    rd(11, 32'h0, "R8 cleared");

    // Level high on pin 63, detection beats clearing write
    wr(9, 32'h8000_0000); idle(3);
    rd(11, 32'h8000_0000, "R7 level high detected");
    wr(11, 32'h0);
    rd(11, 32'h8000_0000, "R9 detection wins over write");
    pins[63] = 1'b0; idle(5);
    wr(11, 32'h0);
    rd(11, 32'h0, "R7 level high gone when pin low");

    // Level low on pin 2
    pins[2] = 1'b0; idle(5);
    rd(10, 32'h4, "R7 level low detected");
    pins[2] = 1'b1; idle(5);
    wr(10, 32'h0);
    rd(10, 32'h0, "R7 level low gone when pin high");

    // Latency on pin 5 (rise armed, enabled)
    pins[5] = 1'b0; idle(5);
    wr(10, 32'h0); idle(1);
    check(wake === 1'b0, "R11 wake low before edge", {31'h0, wake}, 32'h0);
    pins[5] = 1'b1;
    idle(2);
    check(wake === 1'b0, "R11 wake low after two edges", {31'h0, wake}, 32'h0);
    idle(1);
    check(wake === 1'b1, "R11 wake high at third edge", {31'h0, wake}, 32'h1);

    idle(4);
    check(exp_q.size() == 0, "R12 all reads answered", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule